// File: doc/BRIEF.md
# Indirect PHY Register Access Bridge

This block sits on the switch side of a 16-bit register bus and gives a host access to the register files of up to five embedded PHYs. Each PHY has eight pages of thirty-two 16-bit registers. The bridge models them as one memory bank per PHY.

The host first picks a direction by writing a control register. It then writes to an encoded bus address that carries three things:
- a one-hot PHY select,
- the page,
- the register offset.

For a write, the bus data is stored in the addressed PHY register. For a read, the bus data is discarded. The bridge fetches the register and places it in a data register, which the host reads once the busy flag has dropped. An encoded address whose select field is not a legal one-hot value is dropped, and the data register is loaded with all-ones instead.

After reset the bridge clears every PHY register to zero. Clearing runs one register per cycle in all banks at once, and the busy flag is held while it runs.

Top module: `phy_indirect_bridge`

## Requirements
- R1: After reset is released, `busy` stays high for 256 cycles while all PHY registers are cleared. During reset `rd_data` is 0. Every PHY register then reads back 0.
- R2: A bus write to address 0x8028 latches bit 0 of the data as the direction: 1 means read, 0 means write. A bus read of 0x8028 returns the latched direction in bit 0, with the other bits zero.
- R3: An encoded address has bit 15 set, the register offset in bits 4:0, the page in bits 7:5, and a select field in bits 14:9 in which bit (9 + n) chooses PHY n. In write direction, a bus write to a legal encoded address stores the bus data in that PHY, page and register only.
- R4: In read direction, a bus write to a legal encoded address fetches that PHY register. Once `busy` falls, a bus read of 0x8029 returns the fetched value.
- R5: An accepted PHY transaction raises `busy` on the next cycle and holds it for exactly 8 cycles.
- R6: While a transaction is busy, a read of 0x8029 returns the value the data register held before the transaction began.
- R7: An encoded write is dropped when its select field is zero, has more than one bit set, or selects PHY 5 (bit 14). A dropped write does not raise `busy` and stores nothing, and the next read of 0x8029 returns 0xFFFF.
- R8: Encoded bus writes that arrive while `busy` is high are ignored.
- R9: Registers that differ only in page, or only in PHY number, are stored independently.
- R10: Bus reads are registered. `rd_data` changes on the clock edge that samples `bus_rd`. An address that is neither 0x8028 nor 0x8029 reads as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Bus write strobe, one cycle per access |
| bus_rd | input | 1 | Bus read strobe, one cycle per access |
| bus_addr | input | 16 | Bus address |
| bus_wdata | input | 16 | Bus write data |
| rd_data | output | 16 | Registered bus read data |
| busy | output | 1 | High while clearing after reset or while a PHY transaction runs |

## Verification
The bench targets the following corner cases:
- **Select-field decoding.** It tries a zero select, a two-hot select and a select of the nonexistent sixth PHY. A decoder that accepted any of these would corrupt a real PHY register or raise `busy` instead of returning 0xFFFF.
- **Writes during busy.** It fires a second encoded write while a transaction is running. A bridge that did not guard against this would overwrite the first value or start a new transaction.
- **Data read during busy.** It reads the data register mid-transaction. A bridge that loaded the register too early would return the new value there.
- **Timing.** Counted `busy` lengths after reset and after each transaction expose an off-by-one in either counter.
- **Address fields.** Entries that differ only in page or only in PHY catch swapped or truncated address fields.

// File: rtl/phy_bridge_pkg.sv
package phy_bridge_pkg;
  typedef enum logic [1:0] {
    SQ_CLEAR = 2'd0,
    SQ_IDLE  = 2'd1,
    SQ_RUN   = 2'd2
  } seq_state_t;
endpackage

// File: rtl/phy_addr_decode.sv
module phy_addr_decode #(
  parameter int AW        = 16,
  parameter int NUM_PHY   = 5,
  parameter int PAGE_W    = 3,
  parameter int REG_W     = 5,
  parameter int SEL_LSB   = 9,
  parameter logic [AW-1:0] CTRL_ADDR = 16'h8028,
  parameter logic [AW-1:0] DATA_ADDR = 16'h8029,
  localparam int IDX_W    = (NUM_PHY > 1) ? $clog2(NUM_PHY) : 1,
  localparam int LOC_W    = PAGE_W + REG_W,
  localparam int SEL_W    = AW - 1 - SEL_LSB
) (
  input  logic [AW-1:0]      addr,
  output logic               is_ctrl,
  output logic               is_data,
  output logic               is_enc,
  output logic               enc_ok,
  output logic [IDX_W-1:0]   phy_idx,
  output logic [NUM_PHY-1:0] phy_hot,
  output logic [LOC_W-1:0]   loc
);
  logic [SEL_W-1:0] sel_field;

  assign sel_field = addr[AW-2:SEL_LSB];
  assign is_ctrl   = (addr == CTRL_ADDR);
  assign is_data   = (addr == DATA_ADDR);
  assign is_enc    = addr[AW-1] && !is_ctrl && !is_data;
  // legal: exactly one select bit, and it names an existing PHY
  assign enc_ok    = is_enc && $onehot(sel_field) && ((sel_field >> NUM_PHY) == '0);
  assign phy_hot   = enc_ok ? sel_field[NUM_PHY-1:0] : '0;
  assign loc       = addr[LOC_W-1:0];

  always_comb begin
    phy_idx = '0;
    for (int i = 0; i < NUM_PHY; i++) begin
      if (sel_field[i]) phy_idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/phy_regfile_bank.sv
module phy_regfile_bank #(
  parameter int DATA_W = 16,
  parameter int LOC_W  = 8,
  localparam int DEPTH = 1 << LOC_W
) (
  input  logic              clk,
  input  logic              we,
  input  logic              re,
  input  logic [LOC_W-1:0]  addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  // single-port, synchronous read: maps onto a block RAM
  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    if (re) rdata <= mem[addr];
  end
endmodule

// File: rtl/phy_access_seq.sv
module phy_access_seq
  import phy_bridge_pkg::*;
#(
  parameter int LOC_W   = 8,
  parameter int LATENCY = 8,
  localparam int LAT_W  = (LATENCY > 1) ? $clog2(LATENCY) : 1,
  localparam int CW     = (LOC_W > LAT_W) ? LOC_W : LAT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  output logic             busy,
  output logic             clearing,
  output logic [LOC_W-1:0] clr_addr,
  output logic             done
);
  seq_state_t    state;
  logic [CW-1:0] cnt;

  assign busy     = (state != SQ_IDLE);
  assign clearing = (state == SQ_CLEAR);
  assign clr_addr = cnt[LOC_W-1:0];
  assign done     = (state == SQ_RUN) && (cnt == CW'(LATENCY - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= SQ_CLEAR;
      cnt   <= '0;
    end else begin
      case (state)
        SQ_CLEAR: begin
          if (cnt[LOC_W-1:0] == '1) begin
            state <= SQ_IDLE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        SQ_IDLE: begin
          if (start) begin
            state <= SQ_RUN;
            cnt   <= '0;
          end
        end
        SQ_RUN: begin
          if (done) begin
            state <= SQ_IDLE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  // R8: the parent must only launch a transaction when idle
  a_r8_start_when_idle: assert property (@(posedge clk) disable iff (rst)
    start |-> (state == SQ_IDLE));
  // R5: the final counted cycle releases busy
  a_r5_done_releases: assert property (@(posedge clk) disable iff (rst)
    done |=> !busy);
  // R1: the last cleared location ends the clearing phase
  a_r1_clear_ends: assert property (@(posedge clk) disable iff (rst)
    (clearing && clr_addr == '1) |=> !busy);
endmodule

// File: rtl/phy_indirect_bridge.sv
module phy_indirect_bridge #(
  parameter int NUM_PHY  = 5,
  parameter int PAGE_W   = 3,
  parameter int REG_W    = 5,
  parameter int DATA_W   = 16,
  parameter int LATENCY  = 8,
  parameter int SEL_LSB  = 9,
  parameter logic [15:0] CTRL_ADDR = 16'h8028,
  parameter logic [15:0] DATA_ADDR = 16'h8029,
  localparam int AW      = 16,
  localparam int LOC_W   = PAGE_W + REG_W,
  localparam int IDX_W   = (NUM_PHY > 1) ? $clog2(NUM_PHY) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [AW-1:0]     bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] rd_data,
  output logic              busy
);
  logic               dec_ctrl, dec_data, dec_enc, dec_ok;
  logic [IDX_W-1:0]   dec_idx;
  logic [NUM_PHY-1:0] dec_hot;
  logic [LOC_W-1:0]   dec_loc;

  logic               clearing, done, start, bad_access;
  logic [LOC_W-1:0]   clr_addr;

  logic               dir_rd_q;
  logic               run_rd_q;
  logic [IDX_W-1:0]   phy_q;
  logic [DATA_W-1:0]  data_q;
  logic [DATA_W-1:0]  fetched;
  logic [NUM_PHY-1:0] bank_we;
  logic [DATA_W-1:0]  bank_q [NUM_PHY];

  phy_addr_decode #(
    .AW(AW), .NUM_PHY(NUM_PHY), .PAGE_W(PAGE_W), .REG_W(REG_W),
    .SEL_LSB(SEL_LSB), .CTRL_ADDR(CTRL_ADDR), .DATA_ADDR(DATA_ADDR)
  ) u_dec (
    .addr(bus_addr), .is_ctrl(dec_ctrl), .is_data(dec_data),
    .is_enc(dec_enc), .enc_ok(dec_ok), .phy_idx(dec_idx),
    .phy_hot(dec_hot), .loc(dec_loc)
  );

  assign start      = bus_wr && dec_ok && !busy;
  assign bad_access = bus_wr && dec_enc && !dec_ok && !busy;

  phy_access_seq #(.LOC_W(LOC_W), .LATENCY(LATENCY)) u_seq (
    .clk(clk), .rst(rst), .start(start), .busy(busy),
    .clearing(clearing), .clr_addr(clr_addr), .done(done)
  );

  for (genvar g = 0; g < NUM_PHY; g++) begin : g_bank
    assign bank_we[g] = clearing || (start && !dir_rd_q && dec_hot[g]);
    phy_regfile_bank #(.DATA_W(DATA_W), .LOC_W(LOC_W)) u_bank (
      .clk(clk),
      .we(bank_we[g]),
      .re(start && dir_rd_q && dec_hot[g]),
      .addr(clearing ? clr_addr : dec_loc),
      .wdata(clearing ? '0 : bus_wdata),
      .rdata(bank_q[g])
    );
  end

  always_comb begin
    fetched = '0;
    for (int i = 0; i < NUM_PHY; i++) begin
      if (phy_q == IDX_W'(i)) fetched = bank_q[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_rd_q <= 1'b0;
      run_rd_q <= 1'b0;
      phy_q    <= '0;
      data_q   <= '0;
      rd_data  <= '0;
    end else begin
      if (bus_wr && dec_ctrl) dir_rd_q <= bus_wdata[0];
      if (start) begin
        run_rd_q <= dir_rd_q;
        phy_q    <= dec_idx;
      end
      if (bad_access)             data_q <= '1;
      else if (done && run_rd_q)  data_q <= fetched;
      if (bus_rd) begin
        if (dec_ctrl)      rd_data <= {{(DATA_W-1){1'b0}}, dir_rd_q};
        else if (dec_data) rd_data <= data_q;
        else               rd_data <= '0;
      end
    end
  end

  // R7: a dropped access never starts a transaction
  a_r7_bad_no_busy: assert property (@(posedge clk) disable iff (rst)
    bad_access |=> !busy);
  // R7: a dropped access loads all-ones into the data register
  a_r7_bad_ones: assert property (@(posedge clk) disable iff (rst)
    bad_access |=> (data_q == '1));
  // R6: the data register holds its value while a transaction runs
  a_r6_hold_while_busy: assert property (@(posedge clk) disable iff (rst)
    (busy && !done) |=> $stable(data_q));
  // R3: outside clearing at most one bank is written per cycle
  a_r3_one_bank_write: assert property (@(posedge clk) disable iff (rst)
    !clearing |-> $onehot0(bank_we));
endmodule

// File: tb/phy_indirect_bridge_test.sv
module phy_indirect_bridge_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] CTRL = 16'h8028;
  localparam logic [15:0] DATA = 16'h8029;
  localparam int NVEC = 9;
  // {read_op, phy[2:0], page[2:0], reg[4:0], data[15:0]}
  localparam logic [27:0] VEC [NVEC] = '{
    {1'b0, 3'd0, 3'd0, 5'd0,  16'h1111},
    {1'b0, 3'd4, 3'd7, 5'd31, 16'hBEEF},
    {1'b0, 3'd2, 3'd3, 5'd5,  16'h0A0A},
    {1'b0, 3'd2, 3'd4, 5'd5,  16'h5050},
    {1'b1, 3'd0, 3'd0, 5'd0,  16'h1111},
    {1'b1, 3'd4, 3'd7, 5'd31, 16'hBEEF},
    {1'b1, 3'd2, 3'd3, 5'd5,  16'h0A0A},
    {1'b1, 3'd2, 3'd4, 5'd5,  16'h5050},
    {1'b1, 3'd1, 3'd3, 5'd5,  16'h0000}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] rd_data;
  logic        busy;
  int          errors = 0;
  int          checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  phy_indirect_bridge uut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .rd_data(rd_data), .busy(busy)
  );

  function automatic logic [15:0] enc(input int phy, input int page, input int rg);
    return 16'h8000 | (16'h1 << (9 + phy)) | 16'((page & 7) << 5) | 16'(rg & 31);
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [15:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = rd_data;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic phy_wr(input logic [15:0] a, input logic [15:0] d);
    int n;
    bus_write(CTRL, 16'h0000);
    bus_write(a, d);
    wait_idle(n);
  endtask

  task automatic phy_rd(input logic [15:0] a, output logic [15:0] d);
    int n;
    bus_write(CTRL, 16'h0001);
    bus_write(a, 16'h7777);
    wait_idle(n);
    bus_read(DATA, d);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] v;
    int n;

    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 rd_data in reset", rd_data, 16'h0000);
    check("R1 busy in reset", 16'(busy), 16'h0001);
    rst = 1'b0;
    wait_idle(n);
    check("R1 clear length", 16'(n), 16'd256);
    phy_rd(enc(3, 7, 31), v);
    check("R1 cleared register", v, 16'h0000);

    // R2: direction latch readback
    bus_write(CTRL, 16'hFFFF);
    bus_read(CTRL, v);
    check("R2 ctrl read dir", v, 16'h0001);
    bus_write(CTRL, 16'hFFFE);
    bus_read(CTRL, v);
    check("R2 ctrl write dir", v, 16'h0000);

    // R10: unmapped address reads zero
    bus_read(16'h1234, v);
    check("R10 unmapped read", v, 16'h0000);

    // R3 R4 R9: vector table
    for (int i = 0; i < NVEC; i++) begin
      logic [15:0] a;
      a = enc(int'(VEC[i][26:24]), int'(VEC[i][23:21]), int'(VEC[i][20:16]));
      if (VEC[i][27]) begin
        phy_rd(a, v);
        check($sformatf("R4 R9 vector %0d", i), v, VEC[i][15:0]);
      end else begin
        phy_wr(a, VEC[i][15:0]);
      end
    end

    // R5: busy length for a write and a read
    bus_write(CTRL, 16'h0000);
    bus_write(enc(1, 1, 1), 16'h4242);
    wait_idle(n);
    check("R5 write busy length", 16'(n), 16'd8);
    bus_write(CTRL, 16'h0001);
    bus_write(enc(1, 1, 1), 16'h0000);
    wait_idle(n);
    check("R5 read busy length", 16'(n), 16'd8);
    bus_read(DATA, v);
    check("R3 R4 phy1 readback", v, 16'h4242);

    // R6: data register holds old value while busy
    bus_write(enc(4, 7, 31), 16'h0000);
    bus_read(DATA, v);
    check("R6 data read while busy", v, 16'h4242);
    wait_idle(n);
    bus_read(DATA, v);
    check("R6 data after busy", v, 16'hBEEF);

    // R8: writes during busy ignored
    bus_write(CTRL, 16'h0000);
    bus_write(enc(3, 1, 2), 16'hAAAA);
    bus_write(enc(3, 1, 2), 16'hBBBB);
    bus_write(enc(3, 1, 3), 16'hCCCC);
    wait_idle(n);
    phy_rd(enc(3, 1, 2), v);
    check("R8 first write kept", v, 16'hAAAA);
    phy_rd(enc(3, 1, 3), v);
    check("R8 busy write dropped", v, 16'h0000);

    // R7: illegal select fields
    bus_write(CTRL, 16'h0000);
    bus_write(16'h8000 | 16'h0600, 16'hDEAD);   // two-hot PHY 0 and 1
    check("R7 two-hot no busy", 16'(busy), 16'h0000);
    bus_read(DATA, v);
    check("R7 two-hot ones", v, 16'hFFFF);
    phy_rd(enc(0, 0, 0), v);
    check("R7 phy0 untouched", v, 16'h1111);
    phy_rd(enc(1, 0, 0), v);
    check("R7 phy1 untouched", v, 16'h0000);
    bus_write(CTRL, 16'h0001);
    bus_write(16'h8000 | 16'h4000, 16'h0000);   // PHY 5
    check("R7 phy5 no busy", 16'(busy), 16'h0000);
    bus_read(DATA, v);
    check("R7 phy5 ones", v, 16'hFFFF);
    bus_write(enc(0, 0, 0), 16'h0000);
    wait_idle(n);
    bus_write(16'h8025, 16'h0000);               // zero select
    check("R7 zero-select no busy", 16'(busy), 16'h0000);
    bus_read(DATA, v);
    check("R7 zero-select ones", v, 16'hFFFF);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule